// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sits beside the processor of a small microcontroller and owns its power states. Software asks for one of three sleep levels with a two-bit code. Light sleep stops only the processor clock. Deep sleep also stops the main oscillator and the peripheral clocks. The deepest level additionally switches off the brownout detector and the voltage comparators. The block drives one enable line for each clocked or analog function it governs. It watches the interrupt lines to decide when sleep ends. After a deep wake it holds the processor clock off until a stabilisation count has run out.

The block also decides the role of a shared pin. The pin can be an active-low external reset or a plain digital input, chosen by a configuration bit. While power-on reset is in progress the pin is always a reset input. Every reset source returns the controller to the run state. A status output shows the current mode, and a sticky flag tells software whether the last wake came from an interrupt or from a reset.

The controller runs on an always-on clock. Analog circuits are represented only by their enable lines.

Top module: `lpm_rst_ctrl`

## Requirements
- R1: Any reset (power-on, watchdog, brownout, software or pin) forces the run state on the next clock edge. In that state `mode_o`=00, the processor, peripheral and oscillator enables are 1, the stabilisation count is idle and `wake_irq_o`=0.
- R2: When `req_valid_i` is high in the run state with the processor clock on, code 01 enters idle, 10 enters power-down and 11 enters total power-down on the next edge. `mode_o` reports the code. Code 00 leaves the mode unchanged.
- R3: In idle, `cpu_clk_en_o`=0 while `per_clk_en_o` and `osc_en_o` stay 1.
- R4: In idle, any interrupt that is both pending and enabled returns the block to run on the next edge with the processor clock on. A pending interrupt whose enable bit is 0 has no effect.
- R5: In power-down, the processor, peripheral and oscillator enables are 0. `bod_en_o`, `wdt_en_o` and `rtc_en_o` follow their configuration inputs. `cmp_en_o` follows `cmp_cfg_i`.
- R6: In power-down and total power-down, only an interrupt that is pending, enabled and set in `WAKE_MASK` ends the mode. Any other interrupt leaves the mode unchanged.
- R7: After a wake from power-down or total power-down, `mode_o` is 00 and `osc_en_o` is 1, but `cpu_clk_en_o` stays 0 for `STAB_CYC` cycles. Mode requests made in that window are ignored.
- R8: In total power-down, `bod_en_o` and `cmp_en_o` are 0 whatever their configuration inputs.
- R9: In both deep modes, `rc_en_o` is 1 only when `rc_sysclk_i` and `rtc_cfg_i` are both 1. In run and idle it follows `rc_sysclk_i`.
- R10: With `rpe_i`=1, the pin is a reset: `pin_rst_mode_o`=1, a low pin raises `sys_rst_o`, and `pin_data_o` reads 1. With `rpe_i`=0, a low pin raises no reset and `pin_data_o` follows the pin.
- R11: While `por_i` is 1, `pin_rst_mode_o` is 1 even when `rpe_i`=0.
- R12: Watchdog, brownout and software resets leave `pin_rst_mode_o` equal to `rpe_i`.
- R13: `wake_irq_o` becomes 1 on an interrupt wake and keeps its value while sleep modes are entered. Any reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_i | input | 1 | Power-on reset sequence in progress |
| pin_i | input | 1 | Level of the shared reset/data pin |
| rpe_i | input | 1 | Pin role bit: 1 reset, 0 digital input |
| wdt_rst_i | input | 1 | Watchdog reset request |
| bod_rst_i | input | 1 | Brownout reset request |
| sw_rst_i | input | 1 | Software reset request |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode code |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Interrupt enable bits |
| rc_sysclk_i | input | 1 | RC oscillator is the system clock |
| rtc_cfg_i | input | 1 | Real-time clock configured on |
| wdt_cfg_i | input | 1 | Watchdog configured on |
| bod_cfg_i | input | 1 | Brownout detector configured on |
| cmp_cfg_i | input | 1 | Comparators configured on |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| rc_en_o | output | 1 | Internal RC oscillator enable |
| bod_en_o | output | 1 | Brownout detector enable |
| cmp_en_o | output | 1 | Comparator enable |
| wdt_en_o | output | 1 | Watchdog enable |
| rtc_en_o | output | 1 | Real-time clock enable |
| sys_rst_o | output | 1 | Combined system reset |
| pin_rst_mode_o | output | 1 | Shared pin is acting as reset |
| pin_data_o | output | 1 | Digital value read from the shared pin |
| mode_o | output | 2 | Current mode code |
| wake_irq_o | output | 1 | Last wake was by interrupt |

## Verification
A wrong mode register appears on `mode_o` and on the clock enables on the very next edge, so a lost request or a missed wake shows within one cycle. A wake counter that is off by one moves the rise of `cpu_clk_en_o` by exactly one sampled cycle, and the bench checks each cycle of that window. A wrong role for the shared pin is visible at once on `sys_rst_o` and `pin_data_o` without any clock edge. A bad analog-enable decode shows on the deep-mode enables as soon as the mode is entered.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_PD   = 2'b10,
        MODE_TPD  = 2'b11
    } lp_mode_e;
endpackage

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl (
    input  logic por_i,
    input  logic rpe_i,
    input  logic pin_i,
    input  logic wdt_rst_i,
    input  logic bod_rst_i,
    input  logic sw_rst_i,
    output logic pin_rst_mode_o,
    output logic pin_data_o,
    output logic sys_rst_o
);
    logic pin_rst_d;
    logic ext_rst_d;

    always_comb begin
        // only power-on overrides the programmed pin role
        pin_rst_d      = por_i | rpe_i;
        ext_rst_d      = pin_rst_d & ~pin_i;
        pin_rst_mode_o = pin_rst_d;
        pin_data_o     = pin_rst_d ? 1'b1 : pin_i;
        sys_rst_o      = por_i | wdt_rst_i | bod_rst_i | sw_rst_i | ext_rst_d;
    end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
#(
    parameter int              NIRQ      = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK = 4'b0011,
    parameter int              STAB_CYC  = 1024
) (
    input  logic            clk,
    input  logic            por_i,
    input  logic            rst_i,
    input  logic            req_valid_i,
    input  logic [1:0]      req_mode_i,
    input  logic [NIRQ-1:0] irq_pend_i,
    input  logic [NIRQ-1:0] irq_en_i,
    output lp_mode_e        mode_o,
    output logic            stab_busy_o,
    output logic            wake_irq_o
);
    localparam int STAB_W = (STAB_CYC < 1) ? 1 : $clog2(STAB_CYC + 1);
    localparam logic [STAB_W-1:0] STAB_LOAD = STAB_W'(STAB_CYC);

    typedef struct packed {
        lp_mode_e          mode;
        logic [STAB_W-1:0] stab;
        logic              wake_irq;
    } fsm_state_t;

    fsm_state_t state_d, state_q;
    logic [NIRQ-1:0] src_live;
    logic [NIRQ-1:0] src_deep;
    logic            wake_any_d;
    logic            wake_deep_d;

    for (genvar i = 0; i < NIRQ; i++) begin : g_src
        assign src_live[i] = irq_pend_i[i] & irq_en_i[i];
        assign src_deep[i] = src_live[i] & WAKE_MASK[i];
    end

    assign wake_any_d  = |src_live;
    assign wake_deep_d = |src_deep;

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d.mode     = MODE_RUN;
            state_d.stab     = '0;
            state_d.wake_irq = 1'b0;
        end else begin
            unique case (state_q.mode)
                MODE_RUN: begin
                    if (state_q.stab != '0) begin
                        state_d.stab = state_q.stab - STAB_W'(1);
                    end else if (req_valid_i && (req_mode_i != 2'b00)) begin
                        state_d.mode = lp_mode_e'(req_mode_i);
                    end
                end
                MODE_IDLE: begin
                    if (wake_any_d) begin
                        state_d.mode     = MODE_RUN;
                        state_d.wake_irq = 1'b1;
                    end
                end
                default: begin
                    if (wake_deep_d) begin
                        state_d.mode     = MODE_RUN;
                        state_d.stab     = STAB_LOAD;
                        state_d.wake_irq = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign mode_o      = state_q.mode;
    assign stab_busy_o = (state_q.stab != '0);
    assign wake_irq_o  = state_q.wake_irq;

    assert_rst_to_run_R1: assert property (@(posedge clk) disable iff (por_i)
        rst_i |=> (state_q.mode == MODE_RUN) && (state_q.stab == '0) && !state_q.wake_irq);

    assert_req_enter_R2: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && state_q.mode == MODE_RUN && state_q.stab == '0 && req_valid_i
         && req_mode_i != 2'b00) |=> (state_q.mode == lp_mode_e'($past(req_mode_i))));

    assert_deep_hold_R6: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && state_q.mode[1] && !(|(irq_pend_i & irq_en_i & WAKE_MASK)))
        |=> $stable(state_q.mode));

    assert_stab_count_R7: assert property (@(posedge clk) disable iff (por_i)
        (!rst_i && state_q.stab != '0) |=> (state_q.stab == $past(state_q.stab) - STAB_W'(1))
        && (state_q.mode == MODE_RUN));
endmodule

// File: rtl/lpm_en_decode.sv
module lpm_en_decode
    import lpm_pkg::*;
(
    input  lp_mode_e mode_i,
    input  logic     stab_busy_i,
    input  logic     rc_sysclk_i,
    input  logic     rtc_cfg_i,
    input  logic     wdt_cfg_i,
    input  logic     bod_cfg_i,
    input  logic     cmp_cfg_i,
    output logic     cpu_clk_en_o,
    output logic     per_clk_en_o,
    output logic     osc_en_o,
    output logic     rc_en_o,
    output logic     bod_en_o,
    output logic     cmp_en_o,
    output logic     wdt_en_o,
    output logic     rtc_en_o
);
    logic awake_d;
    logic deep_d;

    always_comb begin
        awake_d      = (mode_i == MODE_RUN) || (mode_i == MODE_IDLE);
        deep_d       = !awake_d;
        cpu_clk_en_o = (mode_i == MODE_RUN) && !stab_busy_i;
        per_clk_en_o = awake_d;
        osc_en_o     = awake_d;
        rc_en_o      = deep_d ? (rc_sysclk_i && rtc_cfg_i) : rc_sysclk_i;
        bod_en_o     = bod_cfg_i && (mode_i != MODE_TPD);
        cmp_en_o     = cmp_cfg_i && (mode_i != MODE_TPD);
        wdt_en_o     = wdt_cfg_i;
        rtc_en_o     = rtc_cfg_i;
    end
endmodule

// File: rtl/lpm_rst_ctrl.sv
module lpm_rst_ctrl
    import lpm_pkg::*;
#(
    parameter int              NIRQ      = 4,
    parameter logic [NIRQ-1:0] WAKE_MASK = 4'b0011,
    parameter int              STAB_CYC  = 1024
) (
    input  logic            clk,
    input  logic            por_i,
    input  logic            pin_i,
    input  logic            rpe_i,
    input  logic            wdt_rst_i,
    input  logic            bod_rst_i,
    input  logic            sw_rst_i,
    input  logic            req_valid_i,
    input  logic [1:0]      req_mode_i,
    input  logic [NIRQ-1:0] irq_pend_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic            rc_sysclk_i,
    input  logic            rtc_cfg_i,
    input  logic            wdt_cfg_i,
    input  logic            bod_cfg_i,
    input  logic            cmp_cfg_i,
    output logic            cpu_clk_en_o,
    output logic            per_clk_en_o,
    output logic            osc_en_o,
    output logic            rc_en_o,
    output logic            bod_en_o,
    output logic            cmp_en_o,
    output logic            wdt_en_o,
    output logic            rtc_en_o,
    output logic            sys_rst_o,
    output logic            pin_rst_mode_o,
    output logic            pin_data_o,
    output logic [1:0]      mode_o,
    output logic            wake_irq_o
);
    lp_mode_e mode_q;
    logic     stab_busy_q;
    logic     sys_rst_d;

    lpm_pin_ctrl u_pin (
        .por_i          (por_i),
        .rpe_i          (rpe_i),
        .pin_i          (pin_i),
        .wdt_rst_i      (wdt_rst_i),
        .bod_rst_i      (bod_rst_i),
        .sw_rst_i       (sw_rst_i),
        .pin_rst_mode_o (pin_rst_mode_o),
        .pin_data_o     (pin_data_o),
        .sys_rst_o      (sys_rst_d)
    );

    lpm_mode_fsm #(
        .NIRQ      (NIRQ),
        .WAKE_MASK (WAKE_MASK),
        .STAB_CYC  (STAB_CYC)
    ) u_fsm (
        .clk         (clk),
        .por_i       (por_i),
        .rst_i       (sys_rst_d),
        .req_valid_i (req_valid_i),
        .req_mode_i  (req_mode_i),
        .irq_pend_i  (irq_pend_i),
        .irq_en_i    (irq_en_i),
        .mode_o      (mode_q),
        .stab_busy_o (stab_busy_q),
        .wake_irq_o  (wake_irq_o)
    );

    lpm_en_decode u_en (
        .mode_i       (mode_q),
        .stab_busy_i  (stab_busy_q),
        .rc_sysclk_i  (rc_sysclk_i),
        .rtc_cfg_i    (rtc_cfg_i),
        .wdt_cfg_i    (wdt_cfg_i),
        .bod_cfg_i    (bod_cfg_i),
        .cmp_cfg_i    (cmp_cfg_i),
        .cpu_clk_en_o (cpu_clk_en_o),
        .per_clk_en_o (per_clk_en_o),
        .osc_en_o     (osc_en_o),
        .rc_en_o      (rc_en_o),
        .bod_en_o     (bod_en_o),
        .cmp_en_o     (cmp_en_o),
        .wdt_en_o     (wdt_en_o),
        .rtc_en_o     (rtc_en_o)
    );

    assign sys_rst_o = sys_rst_d;
    assign mode_o    = mode_q;

    assert_tpd_analog_off_R8: assert property (@(posedge clk) disable iff (por_i)
        (mode_o == 2'b11) |-> (!bod_en_o && !cmp_en_o));

    assert_rc_rule_R9: assert property (@(posedge clk) disable iff (por_i)
        mode_o[1] |-> (rc_en_o == (rc_sysclk_i && rtc_cfg_i)));

    assert_pin_role_R12: assert property (@(posedge clk) disable iff (por_i)
        1'b1 |-> (pin_rst_mode_o == rpe_i));

    assert_deep_clocks_off_R5: assert property (@(posedge clk) disable iff (por_i)
        mode_o[1] |-> (!cpu_clk_en_o && !per_clk_en_o && !osc_en_o));
endmodule

// File: tb/lpm_rst_ctrl_test.sv
module lpm_rst_ctrl_test;
    localparam int NIRQ = 2;

    logic clk = 1'b0;
    logic por = 1'b1, pin = 1'b1, rpe = 1'b0;
    logic wdt_rst = 1'b0, bod_rst = 1'b0, sw_rst = 1'b0;
    logic req_v = 1'b0;
    logic [1:0] req_code = 2'b00;
    logic [NIRQ-1:0] pend = '0, en = '1;
    logic rc_sys = 1'b0, rtc_cfg = 1'b1, wdt_cfg = 1'b1, bod_cfg = 1'b1, cmp_cfg = 1'b1;
    logic cpu_en, per_en, osc_en, rc_en, bod_en, cmp_en, wdt_en, rtc_en;
    logic sys_rst, pin_rst_mode, pin_data, wake_irq;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lpm_rst_ctrl #(.NIRQ(NIRQ), .WAKE_MASK(2'b01), .STAB_CYC(3)) uut (
        .clk(clk), .por_i(por), .pin_i(pin), .rpe_i(rpe),
        .wdt_rst_i(wdt_rst), .bod_rst_i(bod_rst), .sw_rst_i(sw_rst),
        .req_valid_i(req_v), .req_mode_i(req_code),
        .irq_pend_i(pend), .irq_en_i(en),
        .rc_sysclk_i(rc_sys), .rtc_cfg_i(rtc_cfg), .wdt_cfg_i(wdt_cfg),
        .bod_cfg_i(bod_cfg), .cmp_cfg_i(cmp_cfg),
        .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
        .rc_en_o(rc_en), .bod_en_o(bod_en), .cmp_en_o(cmp_en),
        .wdt_en_o(wdt_en), .rtc_en_o(rtc_en), .sys_rst_o(sys_rst),
        .pin_rst_mode_o(pin_rst_mode), .pin_data_o(pin_data),
        .mode_o(mode), .wake_irq_o(wake_irq)
    );

    // vector: [9] req valid, [8:7] code, [6:5] irq (0 none, 1 src1 plain, 2 src0 wake-capable),
    //         [4:3] expected mode, [2] cpu, [1] per, [0] osc
    localparam int NVEC = 17;
    localparam logic [9:0] VEC [NVEC] = '{
        10'b1_01_00_01_011,  // R2 enter idle, R3
        10'b0_00_01_00_111,  // R4 any enabled irq wakes idle
        10'b1_00_00_00_111,  // R2 code 00 ignored
        10'b1_10_00_10_000,  // R2 enter power-down, R5
        10'b0_00_01_10_000,  // R6 non-wake source ignored
        10'b0_00_00_10_000,
        10'b0_00_10_00_011,  // R6 wake source, R7 cpu held
        10'b1_01_00_00_011,  // R7 request ignored while stabilising
        10'b0_00_00_00_011,
        10'b0_00_00_00_111,  // R7 cpu after three cycles
        10'b1_11_00_11_000,  // R2 total power-down
        10'b0_00_10_00_011,  // R6 wake from total power-down
        10'b0_00_00_00_011,
        10'b0_00_00_00_011,
        10'b0_00_00_00_111,
        10'b1_01_00_01_011,
        10'b0_00_10_00_111   // R4 idle wake, no stabilisation
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // power-on with rpe=0: pin still a reset (R11)
        #1;
        check("R11 por pin role", 8'(pin_rst_mode), 8'd1);
        pin = 1'b0;
        #1;
        check("R11 por pin low resets", 8'(sys_rst), 8'd1);
        tick();
        tick();
        pin = 1'b1;
        por = 1'b0;
        #1;
        check("R12 pin role after por", 8'(pin_rst_mode), 8'd0);
        pin = 1'b0;
        #1;
        check("R10 digital pin no reset", 8'(sys_rst), 8'd0);
        check("R10 digital pin data", 8'(pin_data), 8'd0);
        pin = 1'b1;
        tick();
        check("R1 reset mode", 8'(mode), 8'd0);
        check("R1 reset clocks", {5'd0, cpu_en, per_en, osc_en}, 8'b111);
        check("R1 reset wake flag", 8'(wake_irq), 8'd0);
        check("R1 reset analog", {4'd0, bod_en, cmp_en, wdt_en, rtc_en}, 8'b1111);

        for (int i = 0; i < NVEC; i++) begin
            req_v    = VEC[i][9];
            req_code = VEC[i][8:7];
            pend     = (VEC[i][6:5] == 2'd1) ? 2'b10 : (VEC[i][6:5] == 2'd2) ? 2'b01 : 2'b00;
            tick();
            req_v    = 1'b0;
            req_code = 2'b00;
            pend     = '0;
            check($sformatf("R2 vector %0d mode", i), 8'(mode), 8'(VEC[i][4:3]));
            check($sformatf("R7 vector %0d clocks", i), {5'd0, cpu_en, per_en, osc_en},
                  {5'd0, VEC[i][2:0]});
        end
        check("R13 flag after irq wake", 8'(wake_irq), 8'd1);

        // R4: pending but disabled irq does not end idle; R13 flag kept
        req_v = 1'b1; req_code = 2'b01;
        tick();
        req_v = 1'b0;
        check("R13 flag kept in idle", 8'(wake_irq), 8'd1);
        en = 2'b00; pend = 2'b11;
        tick();
        check("R4 disabled irq ignored", 8'(mode), 8'd1);
        pend = '0; en = '1;
        // R10: digital pin low in idle changes nothing
        pin = 1'b0;
        #1;
        check("R10 no reset when rpe=0", 8'(sys_rst), 8'd0);
        tick();
        check("R10 mode kept", 8'(mode), 8'd1);
        pin = 1'b1;
        // R12: watchdog reset keeps rpe=0 role, R1 back to run, R13 flag cleared
        wdt_rst = 1'b1;
        #1;
        check("R12 wdt keeps pin role", 8'(pin_rst_mode), 8'd0);
        check("R1 wdt reset asserted", 8'(sys_rst), 8'd1);
        tick();
        wdt_rst = 1'b0;
        check("R1 wdt reset to run", 8'(mode), 8'd0);
        check("R13 flag cleared by reset", 8'(wake_irq), 8'd0);

        // R5 / R9 power-down enables
        rc_sys = 1'b0; rtc_cfg = 1'b1;
        req_v = 1'b1; req_code = 2'b10;
        tick();
        req_v = 1'b0;
        #1;
        check("R5 pd analog", {4'd0, bod_en, cmp_en, wdt_en, rtc_en}, 8'b1111);
        check("R9 pd rc not sysclk", 8'(rc_en), 8'd0);
        rc_sys = 1'b1;
        #1;
        check("R9 pd rc sysclk and rtc", 8'(rc_en), 8'd1);
        rtc_cfg = 1'b0;
        #1;
        check("R9 pd rc without rtc", 8'(rc_en), 8'd0);
        check("R5 pd rtc follows cfg", 8'(rtc_en), 8'd0);
        cmp_cfg = 1'b0;
        #1;
        check("R5 pd comparator own control", 8'(cmp_en), 8'd0);
        cmp_cfg = 1'b1; rtc_cfg = 1'b1;
        // R10 / R1: pin reset with rpe=1 from power-down
        rpe = 1'b1;
        pin = 1'b0;
        #1;
        check("R10 pin reset asserted", 8'(sys_rst), 8'd1);
        check("R10 pin data reads high", 8'(pin_data), 8'd1);
        tick();
        pin = 1'b1;
        check("R1 pin reset to run", 8'(mode), 8'd0);
        check("R1 pin reset clocks", {5'd0, cpu_en, per_en, osc_en}, 8'b111);
        #1;
        check("R9 run rc follows sysclk", 8'(rc_en), 8'd1);

        // R8: total power-down turns off brownout and comparators
        sw_rst = 1'b1;
        #1;
        check("R12 sw reset keeps pin role", 8'(pin_rst_mode), 8'd1);
        tick();
        sw_rst = 1'b0;
        req_v = 1'b1; req_code = 2'b11;
        tick();
        req_v = 1'b0;
        check("R8 tpd mode", 8'(mode), 8'd3);
        check("R8 tpd analog off", {6'd0, bod_en, cmp_en}, 8'b00);
        check("R9 tpd rc rule", 8'(rc_en), 8'd1);
        bod_rst = 1'b1;
        tick();
        bod_rst = 1'b0;
        check("R1 brownout reset to run", 8'(mode), 8'd0);
        check("R8 analog back after reset", {6'd0, bod_en, cmp_en}, 8'b11);

        finish_run();
    end
endmodule